// File: doc/BRIEF.md
# Carry-Coupled Power-of-Two Clock Divider

This block divides a fast source clock by a power of two between 1 and 512. The power is held in a 4-bit ratio code. That code has no write path of its own. It is tied to an 8-bit trim register, which a loop controller nudges one step at a time with up and down request pulses. The ratio code moves only when the trim register overflows past its top or underflows past its bottom. The trim value is exported so that an external delay stage can use it.

The output clock comes from a free-running count of source cycles. It has an even duty cycle for every ratio above one. At ratio one the source clock is passed straight through. A new ratio is adopted only where one output period ends and the next begins, so no high or low phase is ever cut short.

Top module: `pow2_clk_div`

## Requirements
- R1: The output period is 2^K source cycles, where K is the effective ratio code. K = 0 passes the source clock to `clk_out` unchanged (high while the source is high, low while it is low), and K = 9 gives 512.
- R2: For K of 1 or more, `clk_out` is high for the first 2^(K-1) source cycles of each period and low for the rest. It changes only at rising source edges.
- R3: A lone up request raises `fine_q` by one. When `fine_q` is 0xFF and `code_q` is below 9, the request instead sets `fine_q` to 0x00 and raises `code_q` by one.
- R4: A lone down request lowers `fine_q` by one. When `fine_q` is 0x00 and `code_q` is above 0, the request instead sets `fine_q` to 0xFF and lowers `code_q` by one.
- R5: An up request at `fine_q` = 0xFF with `code_q` = 9 leaves both registers unchanged. A down request at `fine_q` = 0x00 with `code_q` = 0 leaves both registers unchanged. `code_q` never exceeds 9, and inside the divider any code from 10 to 15 is treated as 9.
- R6: Up and down requests asserted in the same cycle leave both registers unchanged.
- R7: After reset, `code_q` is 0, `fine_q` is 0x80 and `clk_out` follows the source clock.
- R8: The divider adopts the value of `code_q` only at a rising source edge that ends the current output period. The new period starts at that edge with the output high. A ratio change never shortens a phase.
- R9: Requests are sampled on the rising source edge, and the register values show the result right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_up | input | 1 | Request to raise the trim register by one |
| step_dn | input | 1 | Request to lower the trim register by one |
| clk_out | output | 1 | Divided output clock |
| fine_q | output | 8 | Trim register value |
| code_q | output | 4 | Ratio code (power of two) |

## Verification
The assertions assume that `step_up` and `step_dn` are synchronous to `clk_src` and are stable around its rising edge. They also treat a request that is held high as one new request on every cycle. The bench changes both request lines only shortly after a falling source edge.

The bench uses long single-direction runs to push the code across every carry and borrow from 0 up to 9 and back down. It holds each ratio long enough to see several full periods, then adds random mixes that include simultaneous requests.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

   typedef enum logic [1:0] {
      STEP_NONE = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DN   = 2'd2
   } step_e;

   // Conflicting or absent requests collapse to no step.
   function automatic step_e decode_step(input logic up, input logic dn);
      if (up && !dn)      return STEP_UP;
      else if (dn && !up) return STEP_DN;
      else                return STEP_NONE;
   endfunction

endpackage

// File: rtl/pdiv_fine_stage.sv
module pdiv_fine_stage
   import pdiv_pkg::*;
#(
   parameter int unsigned             FINE_W    = 8,
   parameter int unsigned             CODE_W    = 4,
   parameter int unsigned             MAX_CODE  = 9,
   parameter logic [FINE_W-1:0]       FINE_INIT = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_up,
   input  logic              step_dn,
   output logic [FINE_W-1:0] fine_q,
   output logic [CODE_W-1:0] code_q
);

   localparam logic [FINE_W-1:0] FINE_TOP = '1;
   localparam logic [FINE_W-1:0] FINE_BOT = '0;
   localparam logic [CODE_W-1:0] CODE_TOP = CODE_W'(MAX_CODE);
   localparam logic [CODE_W-1:0] CODE_BOT = '0;

   step_e             req;
   logic [FINE_W-1:0] fine_d;
   logic [CODE_W-1:0] code_d;

   assign req = decode_step(step_up, step_dn);

   always_comb begin
      fine_d = fine_q;
      code_d = code_q;
      case (req)
         STEP_UP: begin
            if (fine_q != FINE_TOP) begin
               fine_d = fine_q + 1'b1;
            end else if (code_q < CODE_TOP) begin
               fine_d = FINE_BOT;
               code_d = code_q + 1'b1;
            end
         end
         STEP_DN: begin
            if (fine_q != FINE_BOT) begin
               fine_d = fine_q - 1'b1;
            end else if (code_q > CODE_BOT) begin
               fine_d = FINE_TOP;
               code_d = code_q - 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fine_q <= FINE_INIT;
         code_q <= CODE_BOT;
      end else begin
         fine_q <= fine_d;
         code_q <= code_d;
      end
   end

endmodule

// File: rtl/pdiv_ratio_gen.sv
module pdiv_ratio_gen #(
   parameter int unsigned CODE_W   = 4,
   parameter int unsigned MAX_CODE = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_in,
   output logic              div_level,
   output logic              bypass
);

   localparam int unsigned   CNT_W   = (MAX_CODE > 0) ? MAX_CODE : 1;
   localparam int unsigned   CODE_HI = (1 << CODE_W) - 1;
   localparam logic [CODE_W-1:0] CODE_TOP = CODE_W'(MAX_CODE);

   logic [CODE_W-1:0] eff_code;
   logic [CODE_W-1:0] act_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W:0]    period;
   logic [CNT_W-1:0]  last_idx;
   logic [CNT_W:0]    half;
   logic [CNT_W:0]    cnt_next;
   logic              boundary;

   // Codes above the top ratio fold onto it; skip the clamp when none exist.
   generate
      if (MAX_CODE < CODE_HI) begin : g_clamp
         assign eff_code = (code_in > CODE_TOP) ? CODE_TOP : code_in;
      end else begin : g_noclamp
         assign eff_code = code_in;
      end
   endgenerate

   assign period   = (CNT_W+1)'(1) << act_q;
   assign last_idx = CNT_W'(period - 1'b1);
   assign half     = period >> 1;
   assign boundary = (cnt_q == last_idx);
   assign cnt_next = {1'b0, cnt_q} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         act_q     <= '0;
         div_level <= 1'b1;
      end else if (boundary) begin
         cnt_q     <= '0;
         act_q     <= eff_code;
         div_level <= 1'b1;
      end else begin
         cnt_q     <= cnt_next[CNT_W-1:0];
         div_level <= (cnt_next < half);
      end
   end

   assign bypass = (act_q == '0);

endmodule

// File: rtl/pow2_clk_div.sv
module pow2_clk_div #(
   parameter int unsigned       FINE_W    = 8,
   parameter int unsigned       CODE_W    = 4,
   parameter int unsigned       MAX_CODE  = 9,
   parameter logic [FINE_W-1:0] FINE_INIT = 8'h80
) (
   input  logic              clk_src,
   input  logic              rst_n,
   input  logic              step_up,
   input  logic              step_dn,
   output logic              clk_out,
   output logic [FINE_W-1:0] fine_q,
   output logic [CODE_W-1:0] code_q
);

   generate
      if (FINE_W < 2) begin : g_bad_fine
         $error("pow2_clk_div: FINE_W must be at least 2");
      end
      if (MAX_CODE >= (1 << CODE_W)) begin : g_bad_code
         $error("pow2_clk_div: MAX_CODE does not fit in CODE_W bits");
      end
      if (MAX_CODE > 24) begin : g_bad_depth
         $error("pow2_clk_div: MAX_CODE too large for the period counter");
      end
   endgenerate

   logic div_level;
   logic bypass;

   pdiv_fine_stage #(
      .FINE_W   (FINE_W),
      .CODE_W   (CODE_W),
      .MAX_CODE (MAX_CODE),
      .FINE_INIT(FINE_INIT)
   ) u_fine (
      .clk    (clk_src),
      .rst_n  (rst_n),
      .step_up(step_up),
      .step_dn(step_dn),
      .fine_q (fine_q),
      .code_q (code_q)
   );

   pdiv_ratio_gen #(
      .CODE_W  (CODE_W),
      .MAX_CODE(MAX_CODE)
   ) u_ratio (
      .clk      (clk_src),
      .rst_n    (rst_n),
      .code_in  (code_q),
      .div_level(div_level),
      .bypass   (bypass)
   );

   assign clk_out = bypass ? clk_src : div_level;

endmodule

// File: rtl/pow2_clk_div_chk.sv
module pow2_clk_div_chk #(
   parameter int unsigned FINE_W   = 8,
   parameter int unsigned CODE_W   = 4,
   parameter int unsigned MAX_CODE = 9
) (
   input logic              clk_src,
   input logic              rst_n,
   input logic              step_up,
   input logic              step_dn,
   input logic [FINE_W-1:0] fine_q,
   input logic [CODE_W-1:0] code_q
);

   localparam logic [FINE_W-1:0] F_TOP = '1;
   localparam logic [FINE_W-1:0] F_BOT = '0;
   localparam logic [CODE_W-1:0] C_TOP = CODE_W'(MAX_CODE);

   a_r5_code_ceiling: assert property (@(posedge clk_src) disable iff (!rst_n)
      code_q <= C_TOP);

   a_r3_carry_steps_code: assert property (@(posedge clk_src) disable iff (!rst_n)
      (step_up && !step_dn && fine_q == F_TOP && code_q < C_TOP)
      |=> (code_q == $past(code_q) + 1'b1) && (fine_q == F_BOT));

   a_r4_borrow_steps_code: assert property (@(posedge clk_src) disable iff (!rst_n)
      (step_dn && !step_up && fine_q == F_BOT && code_q != '0)
      |=> (code_q == $past(code_q) - 1'b1) && (fine_q == F_TOP));

   a_r5_top_hold: assert property (@(posedge clk_src) disable iff (!rst_n)
      (step_up && !step_dn && fine_q == F_TOP && code_q == C_TOP)
      |=> $stable(code_q) && $stable(fine_q));

   a_r5_floor_hold: assert property (@(posedge clk_src) disable iff (!rst_n)
      (step_dn && !step_up && fine_q == F_BOT && code_q == '0)
      |=> $stable(code_q) && $stable(fine_q));

   a_r6_conflict_ignored: assert property (@(posedge clk_src) disable iff (!rst_n)
      (step_up && step_dn) |=> $stable(code_q) && $stable(fine_q));

   a_r9_idle_hold: assert property (@(posedge clk_src) disable iff (!rst_n)
      (!step_up && !step_dn) |=> $stable(code_q) && $stable(fine_q));

   a_r3_code_only_on_wrap: assert property (@(posedge clk_src) disable iff (!rst_n)
      (fine_q != F_TOP && fine_q != F_BOT) |=> $stable(code_q));

endmodule

bind pow2_clk_div pow2_clk_div_chk #(
   .FINE_W  (FINE_W),
   .CODE_W  (CODE_W),
   .MAX_CODE(MAX_CODE)
) i_pow2_clk_div_chk (
   .clk_src(clk_src),
   .rst_n  (rst_n),
   .step_up(step_up),
   .step_dn(step_dn),
   .fine_q (fine_q),
   .code_q (code_q)
);

// File: tb/test_pow2_clk_div.sv
`timescale 1ns/1ps
module test_pow2_clk_div;

   logic       clk_src = 1'b0;
   logic       rst_n   = 1'b0;
   logic       step_up = 1'b0;
   logic       step_dn = 1'b0;
   logic       clk_out;
   logic [7:0] fine_q;
   logic [3:0] code_q;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // reference state
   int m_fine = 128;
   int m_code = 0;
   int m_act  = 0;
   int m_pos  = 0;
   int m_lvl  = 1;

   always #4 clk_src = ~clk_src;

   pow2_clk_div i_pow2_clk_div (
      .clk_src(clk_src),
      .rst_n  (rst_n),
      .step_up(step_up),
      .step_dn(step_dn),
      .clk_out(clk_out),
      .fine_q (fine_q),
      .code_q (code_q)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_edge(input bit up, input bit dn);
      int period;
      period = 1 << m_act;
      if (m_pos == period - 1) begin
         m_pos = 0;
         m_act = (m_code > 9) ? 9 : m_code;
         m_lvl = 1;
      end else begin
         m_pos++;
         m_lvl = (m_pos < period / 2) ? 1 : 0;
      end
      if (up && !dn) begin
         if (m_fine != 255) m_fine++;
         else if (m_code < 9) begin m_code++; m_fine = 0; end
      end else if (dn && !up) begin
         if (m_fine != 0) m_fine--;
         else if (m_code > 0) begin m_code--; m_fine = 255; end
      end
   endtask

   task automatic tick(input bit up, input bit dn);
      step_up = up;
      step_dn = dn;
      @(posedge clk_src);
      model_edge(up, dn);
      #2;
      check("R1 R2 R8 high phase", int'(clk_out), (m_act == 0) ? 1 : m_lvl);
      @(negedge clk_src);
      #1;
      check("R1 R2 R8 low phase", int'(clk_out), (m_act == 0) ? 0 : m_lvl);
      check("R3 R4 R9 fine", int'(fine_q), m_fine);
      check("R3 R4 R9 code", int'(code_q), m_code);
      check("R5 code ceiling", int'(code_q <= 4'd9), 1);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick(1'b0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk_src);
      #1;
      check("R7 reset code", int'(code_q), 0);
      check("R7 reset fine", int'(fine_q), 128);
      check("R7 reset output low phase", int'(clk_out), 0);
      rst_n = 1'b1;
      idle(4);

      // R6: conflicting requests
      for (int i = 0; i < 20; i++) tick(1'b1, 1'b1);
      check("R6 conflict fine", int'(fine_q), 128);

      // down to floor, then one extra ignored borrow (R5)
      for (int i = 0; i < 128; i++) tick(1'b0, 1'b1);
      tick(1'b0, 1'b1);
      check("R5 floor fine", int'(fine_q), 0);
      check("R5 floor code", int'(code_q), 0);

      // climb through every ratio with dwell
      for (int k = 1; k <= 9; k++) begin
         for (int i = 0; i < 256; i++) tick(1'b1, 1'b0);
         check("R3 carry code", int'(code_q), k);
         check("R3 carry fine", int'(fine_q), 0);
         idle(3 << k);
      end

      // ceiling: extra carry ignored (R5)
      for (int i = 0; i < 256; i++) tick(1'b1, 1'b0);
      check("R5 top fine", int'(fine_q), 255);
      check("R5 top code", int'(code_q), 9);
      idle(1100);

      // random mixes including simultaneous requests
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = int'($urandom_range(0, 9));
         tick(r < 4 || r == 9, (r >= 4 && r < 8) || r == 9);
      end

      // descend through every ratio (R4)
      for (int k = 0; k < 10; k++) begin
         for (int i = 0; i < 256; i++) tick(1'b0, 1'b1);
         idle(40);
      end
      for (int i = 0; i < 300; i++) tick(1'b0, 1'b1);
      check("R4 floor reached code", int'(code_q), 0);
      check("R4 floor reached fine", int'(fine_q), 0);
      idle(8);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk_src);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule